// File: doc/BRIEF.md
# Two-Operation Arithmetic Unit with Right-Shift Stage

This block is the arithmetic heart of a small 16-bit datapath. It has only two native operations, ADD and bitwise NOR. Richer operations come from how the operands are presented. A force-zero control replaces the data-register operand with zero, which turns ADD into a plain move and NOR into a move-with-complement. An increment request adds one in the same pass, so subtraction needs only a prior complement of one operand. A second carry input, fed by an external 4-bit displacement adder, is summed in as well. When the same value drives both operands under ADD, the result is that value shifted left by one.

The result and its carry-out are captured in a holding stage on the execute step. At writeback, the stage presents the held value either unshifted or shifted right by one position. A right shift fills the top bit with zero and exposes the bit that was shifted out on a flag. The stage also records whether the held value came from NOR, because such a value must never be written to an address register.

Top module: `addnor_unit`

## Requirements
- R1: After a synchronous active-low reset, `result` is 0, `carry_out` is 0, `shift_flag` is 0 and `addr_dest_ok` is 1.
- R2: With `op_nor`=0 (ADD), a load holds `(dreg + opnd + incr + disp_cy)` modulo 2^16. `carry_out` is 1 exactly when that total exceeds 16 bits.
- R3: With `op_nor`=1 (NOR), a load holds `~(dreg | opnd)`, `carry_out` is 0, and `incr` and `disp_cy` have no effect.
- R4: With `zero_d`=1, `dreg` is treated as zero. ADD then holds `opnd` unchanged (move) and NOR holds `~opnd` (move-complement).
- R5: `incr`=1 adds one in the same pass, so ADD of `a` and `~b` with `incr` gives `a - b` modulo 2^16, with `carry_out`=1 when `a >= b`.
- R6: `disp_cy`=1 adds one more to the sum. With `incr` also set, a total of two is added.
- R7: The stage captures only on a clock edge with `load`=1. Otherwise `result`, `carry_out` and `addr_dest_ok` keep their values.
- R8: With `shift_r`=1, `result` is the held value shifted right by one with bit 15 equal to 0, and `shift_flag` is held bit 0. With `shift_r`=0, `result` is the held value and `shift_flag` is 0. `shift_r` acts combinationally on the held value.
- R9: ADD with the same value `v` on `dreg` and `opnd` holds `v` shifted left by one, with `carry_out` equal to bit 15 of `v`.
- R10: `addr_dest_ok` is 0 while the held value came from a NOR load, and 1 while it came from an ADD load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Capture the computed value into the holding stage |
| dreg | input | 16 | Data-register operand |
| opnd | input | 16 | Second operand (memory, address register or immediate) |
| zero_d | input | 1 | Force the data-register operand to zero |
| op_nor | input | 1 | 1 selects NOR, 0 selects ADD |
| incr | input | 1 | Add one in the same pass |
| disp_cy | input | 1 | Carry from the displacement adder, added into the sum |
| shift_r | input | 1 | Present the held value shifted right by one |
| result | output | 16 | Held value, shifted or unshifted |
| carry_out | output | 1 | Carry beyond bit 15 from the captured ADD |
| shift_flag | output | 1 | Bit shifted out by a right shift |
| addr_dest_ok | output | 1 | Held value may be written to an address register |

## Verification
The ADD path is tried with small values, with all-ones operands that carry out, and with every combination of increment and displacement carry. These separate a missing carry-in, a carry-in counted once instead of twice, and a carry-out dropped at the top. NOR is tried with the carry inputs raised, to show that they leak nowhere. Move, move-complement, subtraction at `a<b`, `a=b` and `a>b`, and the self-add left shift show that the operand gating and the increment work together. Shifted and unshifted reads of values with bit 0 set and with bit 15 set, taken both across a held interval and across a reload, tell the combinational writeback choice apart from the captured value.

// File: rtl/addnor_pkg.sv
// Shared width and operation types for the two-operation arithmetic unit.
package addnor_pkg;
    localparam int WIDTH = 16;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_NOR = 1'b1
    } alu_op_e;
endpackage

// File: rtl/addnor_gate.sv
// Operand gate: replaces the data-register operand with zero when asked.
// Assumes the control is valid in the same cycle as the operand.
module addnor_gate #(
    parameter int W = addnor_pkg::WIDTH
) (
    input  logic [W-1:0] d_in,
    input  logic         force_zero,
    output logic [W-1:0] d_out
);
    // Pass or suppress the data-register operand.
    always_comb begin
        d_out = force_zero ? '0 : d_in;
    end
endmodule

// File: rtl/addnor_core.sv
// Combinational core: ADD with two carry inputs, or bitwise NOR.
// Assumes the carry inputs are meaningful only for ADD.
module addnor_core #(
    parameter int W = addnor_pkg::WIDTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    input  addnor_pkg::alu_op_e  op,
    input  logic                 inc,
    input  logic                 cy_in,
    output logic [W-1:0]         y,
    output logic                 cy_out
);
    localparam int SW = W + 2;

    logic [SW-1:0] total;

    // Full sum with room for the two carry inputs.
    always_comb begin
        total = {2'b00, a} + {2'b00, b} + {{(SW-1){1'b0}}, inc}
              + {{(SW-1){1'b0}}, cy_in};
    end

    // Pick the operation result and its carry-out.
    always_comb begin
        if (op == addnor_pkg::OP_NOR) begin
            y      = ~(a | b);
            cy_out = 1'b0;
        end else begin
            y      = total[W-1:0];
            cy_out = |total[SW-1:W];
        end
    end

    // R3: NOR never produces a carry.
    p_nor_no_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == addnor_pkg::OP_NOR) |-> !cy_out);
    // R9: a self-add carries out the old top bit.
    p_self_add_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == addnor_pkg::OP_ADD && a == b && !inc && !cy_in) |-> (cy_out == a[W-1]));
endmodule

// File: rtl/addnor_shift.sv
// Holding stage: captures result, carry and source kind on load.
// Presents the held value unshifted or shifted right by one.
// Assumes the shift choice arrives at writeback and needs no register.
module addnor_shift #(
    parameter int W = addnor_pkg::WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    input  logic         cy,
    input  logic         from_nor,
    input  logic         shr,
    output logic [W-1:0] held,
    output logic [W-1:0] q,
    output logic         cy_q,
    output logic         out_bit,
    output logic         nor_q
);
    // Capture on load, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held  <= '0;
            cy_q  <= 1'b0;
            nor_q <= 1'b0;
        end else if (load) begin
            held  <= d;
            cy_q  <= cy;
            nor_q <= from_nor;
        end
    end

    // Writeback view: pass through, or shift right and expose bit 0.
    always_comb begin
        if (shr) begin
            q       = {1'b0, held[W-1:1]};
            out_bit = held[0];
        end else begin
            q       = held;
            out_bit = 1'b0;
        end
    end

    // R7: without load the held state does not move.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(held) && $stable(cy_q) && $stable(nor_q)));
    // R8: a right shift always clears the top bit.
    p_shift_top_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shr |-> (q[W-1] == 1'b0));
endmodule

// File: rtl/addnor_unit.sv
// Top: operand gate, ADD/NOR core and the holding/shift stage.
// Assumes the caller suppresses address-register writes when addr_dest_ok is 0.
module addnor_unit #(
    parameter int W = addnor_pkg::WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] dreg,
    input  logic [W-1:0] opnd,
    input  logic         zero_d,
    input  logic         op_nor,
    input  logic         incr,
    input  logic         disp_cy,
    input  logic         shift_r,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         shift_flag,
    output logic         addr_dest_ok
);
    addnor_pkg::alu_op_e op_sel;
    logic [W-1:0] a_gated;
    logic [W-1:0] core_y;
    logic         core_cy;
    logic [W-1:0] held_val;
    logic         nor_held;

    // Map the select bit onto the operation type.
    always_comb begin
        op_sel = op_nor ? addnor_pkg::OP_NOR : addnor_pkg::OP_ADD;
    end

    addnor_gate #(.W(W)) u_gate (
        .d_in       (dreg),
        .force_zero (zero_d),
        .d_out      (a_gated)
    );

    addnor_core #(.W(W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .a      (a_gated),
        .b      (opnd),
        .op     (op_sel),
        .inc    (incr),
        .cy_in  (disp_cy),
        .y      (core_y),
        .cy_out (core_cy)
    );

    addnor_shift #(.W(W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .d        (core_y),
        .cy       (core_cy),
        .from_nor (op_nor),
        .shr      (shift_r),
        .held     (held_val),
        .q        (result),
        .cy_q     (carry_out),
        .out_bit  (shift_flag),
        .nor_q    (nor_held)
    );

    // Address destination is allowed only for ADD results.
    always_comb begin
        addr_dest_ok = ~nor_held;
    end

    // R4: a plain move holds the second operand unchanged.
    p_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && zero_d && !op_nor && !incr && !disp_cy) |=> (held_val == $past(opnd)));
    // R10: a NOR load blocks address-register writes.
    p_nor_blocks_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op_nor) |=> !addr_dest_ok);
endmodule

// File: tb/test_addnor_unit.sv
module test_addnor_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [15:0] dreg = '0;
    logic [15:0] opnd = '0;
    logic        zero_d = 1'b0;
    logic        op_nor = 1'b0;
    logic        incr = 1'b0;
    logic        disp_cy = 1'b0;
    logic        shift_r = 1'b0;
    logic [15:0] result;
    logic        carry_out;
    logic        shift_flag;
    logic        addr_dest_ok;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    addnor_unit i_addnor_unit (
        .clk(clk), .rst_n(rst_n), .load(load), .dreg(dreg), .opnd(opnd),
        .zero_d(zero_d), .op_nor(op_nor), .incr(incr), .disp_cy(disp_cy),
        .shift_r(shift_r), .result(result), .carry_out(carry_out),
        .shift_flag(shift_flag), .addr_dest_ok(addr_dest_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One capture: inputs set at a falling edge, load across one rising edge.
    task automatic run_op(input logic [15:0] d, input logic [15:0] o, input logic z,
                          input logic nr, input logic inc, input logic cy);
        @(negedge clk);
        dreg = d; opnd = o; zero_d = z; op_nor = nr; incr = inc; disp_cy = cy;
        load = 1'b1; shift_r = 1'b0;
        @(negedge clk);
        load = 1'b0;
    endtask

    // Bench model of the ADD path.
    task automatic chk_add(input string req, input logic [15:0] d, input logic [15:0] o,
                           input logic z, input logic inc, input logic cy);
        logic [17:0] t;
        t = {2'b0, (z ? 16'h0 : d)} + {2'b0, o} + {17'b0, inc} + {17'b0, cy};
        run_op(d, o, z, 1'b0, inc, cy);
        chk(req, {16'b0, result}, {16'b0, t[15:0]});
        chk(req, {31'b0, carry_out}, {31'b0, |t[17:16]});
        chk(req, {31'b0, addr_dest_ok}, 32'd1);
    endtask

    task automatic t_reset;
        chk("R1 result", {16'b0, result}, 32'h0);
        chk("R1 carry", {31'b0, carry_out}, 32'h0);
        chk("R1 flag", {31'b0, shift_flag}, 32'h0);
        chk("R1 addr_ok", {31'b0, addr_dest_ok}, 32'h1);
    endtask

    task automatic t_add;
        chk_add("R2 small", 16'h1234, 16'h0101, 1'b0, 1'b0, 1'b0);
        chk_add("R2 carry", 16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b0);
        chk_add("R2 maxsum", 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_nor;
        run_op(16'h0F0F, 16'h00FF, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R3 nor value", {16'b0, result}, {16'b0, 16'hF000});
        chk("R3 nor carry", {31'b0, carry_out}, 32'h0);
        chk("R10 nor blocks addr", {31'b0, addr_dest_ok}, 32'h0);
    endtask

    task automatic t_move;
        chk_add("R4 mov", 16'hBEEF, 16'h5A5A, 1'b1, 1'b0, 1'b0);
        run_op(16'hBEEF, 16'h5A5A, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R4 movc", {16'b0, result}, {16'b0, 16'hA5A5});
    endtask

    task automatic t_sub;
        chk_add("R5 sub a>b", 16'h0009, ~16'h0004, 1'b0, 1'b1, 1'b0);
        chk_add("R5 sub a=b", 16'h0777, ~16'h0777, 1'b0, 1'b1, 1'b0);
        chk_add("R5 sub a<b", 16'h0003, ~16'h0005, 1'b0, 1'b1, 1'b0);
        chk_add("R5 inc only", 16'h00FF, 16'h0000, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_disp;
        chk_add("R6 disp", 16'h0010, 16'h0020, 1'b0, 1'b0, 1'b1);
        chk_add("R6 disp+inc", 16'h0010, 16'h0020, 1'b0, 1'b1, 1'b1);
        chk_add("R6 wrap two", 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_hold;
        run_op(16'h4321, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        dreg = 16'hFFFF; opnd = 16'hFFFF; op_nor = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 hold value", {16'b0, result}, {16'b0, 16'h4321});
        chk("R7 hold addr_ok", {31'b0, addr_dest_ok}, 32'h1);
        chk("R7 hold carry", {31'b0, carry_out}, 32'h0);
    endtask

    task automatic t_shift;
        run_op(16'h8003, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        shift_r = 1'b1;
        #1;
        chk("R8 shifted", {16'b0, result}, {16'b0, 16'h4001});
        chk("R8 flag", {31'b0, shift_flag}, 32'h1);
        shift_r = 1'b0;
        #1;
        chk("R8 unshifted", {16'b0, result}, {16'b0, 16'h8003});
        chk("R8 flag off", {31'b0, shift_flag}, 32'h0);
        run_op(16'h0002, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        shift_r = 1'b1;
        #1;
        chk("R8 even", {16'b0, result}, {16'b0, 16'h0001});
        chk("R8 even flag", {31'b0, shift_flag}, 32'h0);
        shift_r = 1'b0;
    endtask

    task automatic t_shl;
        run_op(16'hC001, 16'hC001, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 shl value", {16'b0, result}, {16'b0, 16'h8002});
        chk("R9 shl carry", {31'b0, carry_out}, 32'h1);
        run_op(16'h1234, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 shl no carry", {31'b0, carry_out}, 32'h0);
    endtask

    task automatic t_addr_ok;
        run_op(16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R10 after nor", {31'b0, addr_dest_ok}, 32'h0);
        run_op(16'h0001, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10 after add", {31'b0, addr_dest_ok}, 32'h1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_nor();
        t_move();
        t_sub();
        t_disp();
        t_hold();
        t_shift();
        t_shl();
        t_addr_ok();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule